// File: doc/BRIEF.md
# Burst-Wrap Read Address Generator

This block supplies the byte address sequence for a continuous read out of a serial flash array. A read command starts it with a 24-bit or 32-bit start address. It then waits through a programmable number of dummy cycles. After that, each data request advances the address by one byte. The address either circles inside an aligned window of 8, 16, 32 or 64 bytes, or runs straight through the array and rolls over to zero at the top.

The read behaviour comes from an 8-bit read-parameter register. The block holds the volatile working copy of that register. During reset the copy loads from a non-volatile shadow input, and the register port can overwrite it at any later time. The register holds a pin-function select bit (HOLD or RESET), a four-bit dummy-cycle code, a wrap-enable bit and a two-bit burst-length code. When the dummy code is zero, the command supplies the dummy count instead.

Top module: `wrap_read_addr_gen`

## Requirements
- R1: While rst_n is low, the volatile copy loads from nv_cfg_i. After reset, cfg_o shows that value, and hold_reset_sel_o equals its bit 7.
- R2: A clock edge with cfg_wr_i high replaces the volatile copy with cfg_wdata_i. The bit fields are: [7] HOLD/RESET select, [6:3] dummy code, [2] wrap enable, [1:0] length code.
- R3: With wrap enabled, the length code selects the window size: 00 gives 8 bytes, 01 gives 16, 10 gives 32 and 11 gives 64. Each step keeps the address bits above the window and increments the low bits modulo the window size.
- R4: With wrap disabled, every step adds one whatever the length code holds. The address rolls over from the last array byte to 0. The last array byte is 2^ARRAY_AW-1 in 4-byte mode and 2^24-1 in 3-byte mode.
- R5: The start address is cut to the array in 4-byte mode (addr4_i=1) and to 24 bits in 3-byte mode (addr4_i=0).
- R6: A nonzero dummy code N means data_ready_o rises exactly N clock edges after the edge that samples start_i. dummy_o is high for those N cycles.
- R7: A dummy code of 0 uses dflt_dummy_i, sampled with start_i. When that value is also 0, data_ready_o is high straight after the start edge.
- R8: data_req_i has no effect on addr_o while data_ready_o is low, both during the dummy phase and when idle.
- R9: The wrap enable and the length code are captured at start. A register write during a burst does not change how the current burst steps.
- R10: stop_i ends the burst. data_ready_o drops after that edge, and later requests leave addr_o unchanged. start_i takes priority over stop_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the volatile copy |
| nv_cfg_i | input | 8 | Non-volatile shadow of the read-parameter register |
| cfg_wr_i | input | 1 | Write strobe for the volatile copy |
| cfg_wdata_i | input | 8 | New value for the volatile copy |
| addr4_i | input | 1 | 1 = 4-byte addressing, 0 = 3-byte |
| start_i | input | 1 | Starts a read burst |
| start_addr_i | input | 32 | Start byte address |
| dflt_dummy_i | input | 4 | Per-command dummy count used when the register code is 0 |
| stop_i | input | 1 | Ends the current burst |
| data_req_i | input | 1 | Advance to the next byte |
| cfg_o | output | 8 | Volatile copy of the register |
| hold_reset_sel_o | output | 1 | HOLD/RESET pin-function select |
| dummy_o | output | 1 | Dummy phase in progress |
| data_ready_o | output | 1 | addr_o is valid for data |
| addr_o | output | 32 | Current byte address |

## Verification
The bench drives the wrap point of every window size from a start offset near the top of the window. A generator that masked the wrong number of bits would carry into the upper address bits or wrap early. Linear runs start two bytes below the top of the array in both address modes, so a missing or wrongly sized rollover shows up as an out-of-array address. Dummy timing is checked edge by edge for codes 3, 15 and the zero code, using both a nonzero and a zero default, so an off-by-one count moves data_ready_o by one cycle. A register write in the middle of a wrapping burst, and requests sent during dummy, idle and stopped phases, catch a design that reads live configuration or steps the address when it should not.

// File: rtl/wrap_rd_pkg.sv
package wrap_rd_pkg;
   localparam int CFG_W   = 8;
   localparam int DUM_W   = 4;
   localparam int LEN_W   = 2;

   typedef struct packed {
      logic             hold_sel;  // [7]
      logic [DUM_W-1:0] dummy;     // [6:3]
      logic             wrap_en;   // [2]
      logic [LEN_W-1:0] len;       // [1:0]
   } rd_cfg_t;
endpackage

// File: rtl/rd_cfg_reg.sv
module rd_cfg_reg
   import wrap_rd_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] nv_i,
   input  logic             wr_i,
   input  logic [CFG_W-1:0] wdata_i,
   output rd_cfg_t          cfg_o
);
   rd_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cfg_q <= rd_cfg_t'(nv_i);
      else if (wr_i) cfg_q <= rd_cfg_t'(wdata_i);
   end

   assign cfg_o = cfg_q;

   a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (cfg_q == rd_cfg_t'($past(wdata_i))));

   a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && $past(rst_n)) |=> $stable(cfg_q));
endmodule

// File: rtl/rd_dummy_cnt.sv
module rd_dummy_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= count_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(count_i)));
endmodule

// File: rtl/rd_addr_step.sv
module rd_addr_step #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 2,
   parameter int BASE_LOG2 = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wrap_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] lim_i,
   output logic [ADDR_W-1:0] win_o,
   output logic [ADDR_W-1:0] next_o
);
   localparam int MAX_LOG2 = BASE_LOG2 + (1 << LEN_W) - 1;

   if (MAX_LOG2 >= ADDR_W) begin : g_bad
      $error("window larger than address");
   end

   logic [ADDR_W-1:0] win;
   logic [ADDR_W-1:0] inc;

   for (genvar b = 0; b < ADDR_W; b++) begin : g_win
      if (b < BASE_LOG2) begin : g_base
         assign win[b] = 1'b1;
      end else if (b < MAX_LOG2) begin : g_sel
         assign win[b] = ({1'b0, len_i} > (LEN_W+1)'(b - BASE_LOG2));
      end else begin : g_out
         assign win[b] = 1'b0;
      end
   end

   assign inc    = addr_i + 1'b1;
   assign win_o  = win;
   assign next_o = wrap_i ? ((addr_i & ~win) | (inc & win)) : (inc & lim_i);
endmodule

// File: rtl/wrap_read_addr_gen.sv
module wrap_read_addr_gen
   import wrap_rd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int ARRAY_AW  = 25,
   parameter int SHORT_AW  = 24,
   parameter int BASE_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  nv_cfg_i,
   input  logic              cfg_wr_i,
   input  logic [CFG_W-1:0]  cfg_wdata_i,
   input  logic              addr4_i,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [DUM_W-1:0]  dflt_dummy_i,
   input  logic              stop_i,
   input  logic              data_req_i,
   output logic [CFG_W-1:0]  cfg_o,
   output logic              hold_reset_sel_o,
   output logic              dummy_o,
   output logic              data_ready_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int SHORT_EFF = (SHORT_AW < ARRAY_AW) ? SHORT_AW : ARRAY_AW;
   localparam logic [ADDR_W-1:0] ARR_MASK   = ADDR_W'((64'd1 << ARRAY_AW) - 64'd1);
   localparam logic [ADDR_W-1:0] SHORT_MASK = ADDR_W'((64'd1 << SHORT_EFF) - 64'd1);
   localparam int MAX_LOG2 = BASE_LOG2 + (1 << LEN_W) - 1;

   if (ARRAY_AW > ADDR_W || ARRAY_AW <= MAX_LOG2) begin : g_chk_array
      $error("ARRAY_AW out of range");
   end
   if (SHORT_AW <= MAX_LOG2) begin : g_chk_short
      $error("SHORT_AW out of range");
   end

   rd_cfg_t           cfg;
   logic              busy_q;
   logic              wrap_q;
   logic [LEN_W-1:0]  len_q;
   logic [ADDR_W-1:0] lim_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] next_addr;
   logic [ADDR_W-1:0] win_mask;
   logic [ADDR_W-1:0] lim_new;
   logic [DUM_W-1:0]  dummy_eff;
   logic              cnt_done;
   logic              ready;

   rd_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .nv_i    (nv_cfg_i),
      .wr_i    (cfg_wr_i),
      .wdata_i (cfg_wdata_i),
      .cfg_o   (cfg)
   );

   assign dummy_eff = (cfg.dummy == '0) ? dflt_dummy_i : cfg.dummy;

   rd_dummy_cnt #(.CNT_W(DUM_W)) u_dummy (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (start_i),
      .count_i (dummy_eff),
      .done_o  (cnt_done)
   );

   rd_addr_step #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .BASE_LOG2 (BASE_LOG2)
   ) u_step (
      .addr_i (addr_q),
      .wrap_i (wrap_q),
      .len_i  (len_q),
      .lim_i  (lim_q),
      .win_o  (win_mask),
      .next_o (next_addr)
   );

   assign lim_new = addr4_i ? ARR_MASK : SHORT_MASK;
   assign ready   = busy_q & cnt_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wrap_q <= 1'b0;
         len_q  <= '0;
         lim_q  <= ARR_MASK;
         addr_q <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         wrap_q <= cfg.wrap_en;
         len_q  <= cfg.len;
         lim_q  <= lim_new;
         addr_q <= start_addr_i & lim_new;
      end else if (stop_i) begin
         busy_q <= 1'b0;
      end else if (ready && data_req_i) begin
         addr_q <= next_addr;
      end
   end

   assign cfg_o            = cfg;
   assign hold_reset_sel_o = cfg.hold_sel;
   assign dummy_o          = busy_q & ~cnt_done;
   assign data_ready_o     = ready;
   assign addr_o           = addr_q;

   a_r3_wrap_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && data_req_i && wrap_q && !start_i && !stop_i)
      |=> ((addr_q & ~win_mask) == ($past(addr_q) & ~win_mask)));

   a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && data_req_i && !wrap_q && !start_i && !stop_i)
      |=> (addr_q == (($past(addr_q) + 1'b1) & lim_q)));

   a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ((addr_q & ~lim_q) == '0));

   a_r8_no_step_unready: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !start_i) |=> $stable(addr_q));

   a_r10_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !data_ready_o);
endmodule

// File: tb/wrap_read_addr_gen_tb.sv
module wrap_read_addr_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  nv_cfg;
   logic        cfg_wr;
   logic [7:0]  cfg_wdata;
   logic        addr4;
   logic        start;
   logic [31:0] start_addr;
   logic [3:0]  dflt_dummy;
   logic        stop;
   logic        req;
   logic [7:0]  cfg_o;
   logic        hold_sel;
   logic        dummy_o;
   logic        ready;
   logic [31:0] addr_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wrap_read_addr_gen u_dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .nv_cfg_i         (nv_cfg),
      .cfg_wr_i         (cfg_wr),
      .cfg_wdata_i      (cfg_wdata),
      .addr4_i          (addr4),
      .start_i          (start),
      .start_addr_i     (start_addr),
      .dflt_dummy_i     (dflt_dummy),
      .stop_i           (stop),
      .data_req_i       (req),
      .cfg_o            (cfg_o),
      .hold_reset_sel_o (hold_sel),
      .dummy_o          (dummy_o),
      .data_ready_o     (ready),
      .addr_o           (addr_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mkcfg(input logic hs, input logic [3:0] d,
                                        input logic w, input logic [1:0] l);
      return {hs, d, w, l};
   endfunction

   function automatic logic [31:0] mnext(input logic [31:0] a, input logic w,
                                         input logic [1:0] l, input logic a4);
      logic [31:0] lim;
      logic [31:0] m;
      lim = a4 ? 32'h01FF_FFFF : 32'h00FF_FFFF;
      m   = (32'd8 << l) - 32'd1;
      if (w) return (a & ~m) | ((a + 32'd1) & m);
      return (a + 32'd1) & lim;
   endfunction

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // Starts a burst and checks dummy timing for n dummy edges.
   task automatic begin_burst(input logic [31:0] a, input logic a4,
                              input logic [3:0] dflt, input int n, input string tag);
      @(negedge clk);
      start = 1'b1; start_addr = a; addr4 = a4; dflt_dummy = dflt;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < n; k++) begin
         chk({tag, " ready low in dummy"}, {31'd0, ready}, 32'd0);
         chk({tag, " dummy_o high"}, {31'd0, dummy_o}, 32'd1);
         @(negedge clk);
      end
      chk({tag, " ready after dummy"}, {31'd0, ready}, 32'd1);
      chk({tag, " dummy_o low"}, {31'd0, dummy_o}, 32'd0);
   endtask

   task automatic run_steps(input logic [31:0] a0, input logic w, input logic [1:0] l,
                            input logic a4, input int n, input string tag);
      logic [31:0] exp;
      exp = a0;
      chk({tag, " first addr"}, addr_o, exp);
      req = 1'b1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         exp = mnext(exp, w, l, a4);
         chk({tag, " step"}, addr_o, exp);
      end
      req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cfg after reset", {24'd0, cfg_o}, {24'd0, 8'hA5});
      chk("R1 hold select", {31'd0, hold_sel}, 32'd1);
      chk("R10 idle not ready", {31'd0, ready}, 32'd0);
   endtask

   task automatic t_cfg_write();
      write_cfg(mkcfg(1'b0, 4'd3, 1'b1, 2'b01));
      chk("R2 cfg written", {24'd0, cfg_o}, {24'd0, mkcfg(1'b0, 4'd3, 1'b1, 2'b01)});
      chk("R2 hold select field", {31'd0, hold_sel}, 32'd0);
   endtask

   task automatic t_wrap16();
      begin_burst(32'h0012_343C, 1'b1, 4'd0, 3, "R6 code3");
      run_steps(32'h0012_343C, 1'b1, 2'b01, 1'b1, 20, "R3 wrap16");
   endtask

   task automatic t_wrap_all();
      for (int l = 0; l < 4; l++) begin
         write_cfg(mkcfg(1'b0, 4'd1, 1'b1, 2'(l)));
         begin_burst(32'h01AB_CDFD, 1'b1, 4'd0, 1, "R6 code1");
         run_steps(32'h01AB_CDFD, 1'b1, 2'(l), 1'b1, 70, "R3 wrap len");
      end
   endtask

   task automatic t_linear4();
      write_cfg(mkcfg(1'b0, 4'd2, 1'b0, 2'b11));
      begin_burst(32'hFFFF_FFFE, 1'b1, 4'd0, 2, "R6 code2");
      chk("R5 4-byte start cut", addr_o, 32'h01FF_FFFE);
      run_steps(32'h01FF_FFFE, 1'b0, 2'b11, 1'b1, 5, "R4 linear rollover 4B");
   endtask

   task automatic t_linear3();
      begin_burst(32'hABFF_FFFE, 1'b0, 4'd0, 2, "R6 code2 3B");
      chk("R5 3-byte start cut", addr_o, 32'h00FF_FFFE);
      run_steps(32'h00FF_FFFE, 1'b0, 2'b11, 1'b0, 4, "R4 linear rollover 3B");
   endtask

   task automatic t_default_dummy();
      write_cfg(mkcfg(1'b0, 4'd0, 1'b0, 2'b00));
      begin_burst(32'h0000_0100, 1'b1, 4'd5, 5, "R7 default 5");
      begin_burst(32'h0000_0200, 1'b1, 4'd0, 0, "R7 default 0");
      chk("R7 default 0 addr", addr_o, 32'h0000_0200);
   endtask

   task automatic t_max_dummy_and_ignore();
      write_cfg(mkcfg(1'b0, 4'd15, 1'b1, 2'b00));
      @(negedge clk);
      start = 1'b1; start_addr = 32'h0000_0047; addr4 = 1'b1;
      @(negedge clk);
      start = 1'b0; req = 1'b1;
      for (int k = 0; k < 15; k++) begin
         chk("R8 req during dummy ignored", addr_o, 32'h0000_0047);
         chk("R6 code15 ready low", {31'd0, ready}, 32'd0);
         @(negedge clk);
      end
      req = 1'b0;
      chk("R6 code15 ready", {31'd0, ready}, 32'd1);
      chk("R8 addr before first step", addr_o, 32'h0000_0047);
      run_steps(32'h0000_0047, 1'b1, 2'b00, 1'b1, 3, "R3 wrap8");
   endtask

   task automatic t_midburst_write();
      write_cfg(mkcfg(1'b0, 4'd1, 1'b1, 2'b01));
      begin_burst(32'h0000_001D, 1'b1, 4'd0, 1, "R6 code1 mid");
      write_cfg(mkcfg(1'b0, 4'd1, 1'b0, 2'b11));
      run_steps(32'h0000_001D, 1'b1, 2'b01, 1'b1, 6, "R9 snapshot");
   endtask

   task automatic t_stop();
      logic [31:0] held;
      held = addr_o;
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R10 ready dropped", {31'd0, ready}, 32'd0);
      req = 1'b1;
      repeat (3) @(negedge clk);
      req = 1'b0;
      chk("R10 addr held after stop", addr_o, held);
      chk("R8 idle req ignored", {31'd0, ready}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; nv_cfg = 8'hA5; cfg_wr = 1'b0; cfg_wdata = 8'h00;
      addr4 = 1'b1; start = 1'b0; start_addr = '0; dflt_dummy = '0;
      stop = 1'b0; req = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg_write();
      t_wrap16();
      t_wrap_all();
      t_linear4();
      t_linear3();
      t_default_dummy();
      t_max_dummy_and_ignore();
      t_midburst_write();
      t_stop();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule